// File: doc/BRIEF.md
# SAO Offset and Distortion Generator

This block sits between the statistics collector and the parameter decision logic of a sample-adaptive-offset encoder. Each cycle it takes one classification as a pair of values. The first is the sample count C. The second is the signed sum S of original-minus-reconstructed differences. From this pair it produces the offset the classification would receive and the distortion change that offset causes. The offset is the quotient S/C rounded to the nearest integer and limited to plus or minus seven. No divider and no search over candidate offsets are used. The block instead compares twice the magnitude of S with odd multiples of C. The distortion change is O·O·C − 2·O·S.

A caller streams the 48 classifications of the current coding tree block back to back, one per cycle, each with an index that travels with it through the pipeline. When merge candidates are evaluated, the caller streams the four classifications of the left or upper neighbour. For those it raises the override flag and supplies the neighbour's stored offset, and the block then skips rounding and only computes the distortion for that offset. Results come out three cycles after the input, at a rate of one per cycle.

Top module: `sao_ofs_dist_gen`

## Requirements
- R1: With override low and C nonzero, the offset magnitude equals the number of n in 0..6 for which 2·|S| is strictly greater than (2n+1)·C.
- R2: With override low, a nonzero offset has the sign of S. `out_ofs` is a 4-bit two's complement value.
- R3: A quotient whose fractional part is exactly one half rounds toward zero (S=3, C=6 gives 0; S=9, C=6 gives 1; S=39, C=6 gives 6).
- R4: With override low and C equal to zero, the offset is 0 and the distortion is 0, whatever S is.
- R5: `out_dist` equals O·O·C − 2·O·S, where O is the offset being reported and C and S belong to the same input. It is exact in signed 27-bit two's complement for every legal input.
- R6: With override high, the reported offset is `in_ovr_ofs` unchanged, and the distortion is computed with that offset, including when C is zero.
- R7: `out_vld` equals `in_vld` from three clock edges earlier. A new input is accepted every cycle.
- R8: `out_idx` returns the `in_idx` of the input that produced the result.
- R9: While `rst_n` is low, and until inputs presented after its release have travelled through the pipeline, `out_vld` is low.
- R10: Offsets saturate at +7 and −7 when the rounded quotient exceeds seven in magnitude, including for the extreme sum values −2^20 and 2^20−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input pair valid |
| in_idx | input | 6 | Classification index carried to the output |
| in_cnt | input | 13 | Sample count C (unsigned) |
| in_sum | input | 21 | Difference sum S (signed) |
| in_ovr | input | 1 | Use the supplied offset instead of rounding |
| in_ovr_ofs | input | 4 | Supplied neighbour offset (signed) |
| out_vld | output | 1 | Result valid |
| out_idx | output | 6 | Index of the result |
| out_ofs | output | 4 | Offset (signed, −7..+7) |
| out_dist | output | 27 | Distortion change O·O·C − 2·O·S (signed) |

## Verification
The rounding is tried with pairs whose quotients fall just above, just below and exactly on a half-integer. This separates a strict comparison from a non-strict one and shows the half-toward-zero rule in both signs. Quotients far beyond seven, the most negative and most positive sums, and a count of zero show saturation and the zero-count guard. Override pairs, one of them with a zero count, show that the supplied offset bypasses rounding while the distortion still follows it. Back-to-back streaming, an isolated single input and a reset in mid-stream show the three-cycle alignment of valid, index and data.

// File: rtl/sao_ofs_pkg.sv
package sao_ofs_pkg;
  // Default geometry: a 64x64 block gives counts up to 4096 and sums of
  // clipped 8-bit differences that fit in 21 signed bits.
  localparam int unsigned CNT_W_DEF   = 13;
  localparam int unsigned SUM_W_DEF   = 21;
  localparam int unsigned IDX_W_DEF   = 6;
  localparam int unsigned OFS_MAX_DEF = 7;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned PIPE_LAT    = 3;

  function automatic int unsigned ofs_width(input int unsigned max_mag);
    return $clog2(max_mag + 1) + 1;
  endfunction
endpackage

// File: rtl/sao_rst_sync.sv
module sao_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sao_thresh_stage.sv
module sao_thresh_stage #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned SUM_W   = 21,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned OFS_MAX = 7,
  parameter int unsigned OFS_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    a_vld,
  input  logic [IDX_W-1:0]        a_idx,
  input  logic [CNT_W-1:0]        a_cnt,
  input  logic signed [SUM_W-1:0] a_sum,
  input  logic                    a_ovr,
  input  logic signed [OFS_W-1:0] a_ovr_ofs,
  output logic                    b_vld,
  output logic [IDX_W-1:0]        b_idx,
  output logic [CNT_W-1:0]        b_cnt,
  output logic signed [SUM_W-1:0] b_sum,
  output logic                    b_ovr,
  output logic signed [OFS_W-1:0] b_ovr_ofs,
  output logic                    b_neg,
  output logic [OFS_MAX-1:0]      b_hits
);
  localparam int unsigned CMP_W = SUM_W + CNT_W + 2;

  logic [SUM_W-1:0]   mag_s;
  logic [CMP_W-1:0]   twice_mag;
  logic [OFS_MAX-1:0] hits_d;
  logic               neg_d;
  logic               cnt_nz;

  always_comb begin
    neg_d     = a_sum[SUM_W-1];
    mag_s     = neg_d ? SUM_W'(-a_sum) : SUM_W'(a_sum);
    twice_mag = CMP_W'(mag_s) << 1;
    cnt_nz    = (a_cnt != '0);
  end

  // One comparator per half-integer step: 2|S| > (2n+1)*C.
  for (genvar n = 0; n < OFS_MAX; n++) begin : g_step
    logic [CMP_W-1:0] bound;
    always_comb begin
      bound     = CMP_W'(a_cnt) * CMP_W'(2 * n + 1);
      hits_d[n] = cnt_nz && (twice_mag > bound);
    end
  end

  logic vld_q;
  logic ld_en;

  always_comb begin
    ld_en = a_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= a_vld;
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      b_idx     <= a_idx;
      b_cnt     <= a_cnt;
      b_sum     <= a_sum;
      b_ovr     <= a_ovr;
      b_ovr_ofs <= a_ovr_ofs;
      b_neg     <= neg_d;
      b_hits    <= hits_d;
    end
  end

  assign b_vld = vld_q;
endmodule

// File: rtl/sao_ofs_round.sv
module sao_ofs_round #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned SUM_W   = 21,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned OFS_MAX = 7,
  parameter int unsigned OFS_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    b_vld,
  input  logic [IDX_W-1:0]        b_idx,
  input  logic [CNT_W-1:0]        b_cnt,
  input  logic signed [SUM_W-1:0] b_sum,
  input  logic                    b_ovr,
  input  logic signed [OFS_W-1:0] b_ovr_ofs,
  input  logic                    b_neg,
  input  logic [OFS_MAX-1:0]      b_hits,
  output logic                    c_vld,
  output logic [IDX_W-1:0]        c_idx,
  output logic [CNT_W-1:0]        c_cnt,
  output logic signed [SUM_W-1:0] c_sum,
  output logic signed [OFS_W-1:0] c_ofs
);
  logic [OFS_W-1:0]        mag;
  logic signed [OFS_W-1:0] rnd_ofs;
  logic signed [OFS_W-1:0] ofs_d;

  always_comb begin
    mag = '0;
    for (int k = 0; k < OFS_MAX; k++) begin
      mag = mag + OFS_W'(b_hits[k]);
    end
    rnd_ofs = b_neg ? -$signed(mag) : $signed(mag);
    ofs_d   = b_ovr ? b_ovr_ofs : rnd_ofs;
  end

  logic vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= b_vld;
  end

  always_ff @(posedge clk) begin
    if (b_vld) begin
      c_idx <= b_idx;
      c_cnt <= b_cnt;
      c_sum <= b_sum;
      c_ofs <= ofs_d;
    end
  end

  assign c_vld = vld_q;
endmodule

// File: rtl/sao_dist_calc.sv
module sao_dist_calc #(
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned SUM_W  = 21,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned OFS_W  = 4,
  parameter int unsigned DIST_W = 27
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     c_vld,
  input  logic [IDX_W-1:0]         c_idx,
  input  logic [CNT_W-1:0]         c_cnt,
  input  logic signed [SUM_W-1:0]  c_sum,
  input  logic signed [OFS_W-1:0]  c_ofs,
  output logic                     d_vld,
  output logic [IDX_W-1:0]         d_idx,
  output logic signed [OFS_W-1:0]  d_ofs,
  output logic signed [DIST_W-1:0] d_dist
);
  logic signed [DIST_W-1:0] o_x;
  logic signed [DIST_W-1:0] c_x;
  logic signed [DIST_W-1:0] s_x;
  logic signed [DIST_W-1:0] sq_term;
  logic signed [DIST_W-1:0] cross_term;
  logic signed [DIST_W-1:0] dist_d;

  always_comb begin
    o_x        = DIST_W'(c_ofs);
    c_x        = DIST_W'({1'b0, c_cnt});
    s_x        = DIST_W'(c_sum);
    sq_term    = o_x * o_x * c_x;
    cross_term = (o_x * s_x) <<< 1;
    dist_d     = sq_term - cross_term;
  end

  logic vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= c_vld;
  end

  always_ff @(posedge clk) begin
    if (c_vld) begin
      d_idx  <= c_idx;
      d_ofs  <= c_ofs;
      d_dist <= dist_d;
    end
  end

  assign d_vld = vld_q;
endmodule

// File: rtl/sao_ofs_dist_gen.sv
module sao_ofs_dist_gen
  import sao_ofs_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned SUM_W   = SUM_W_DEF,
  parameter int unsigned IDX_W   = IDX_W_DEF,
  parameter int unsigned OFS_MAX = OFS_MAX_DEF,
  localparam int unsigned OFS_W  = ofs_width(OFS_MAX),
  localparam int unsigned DIST_W = SUM_W + OFS_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic [IDX_W-1:0]         in_idx,
  input  logic [CNT_W-1:0]         in_cnt,
  input  logic signed [SUM_W-1:0]  in_sum,
  input  logic                     in_ovr,
  input  logic signed [OFS_W-1:0]  in_ovr_ofs,
  output logic                     out_vld,
  output logic [IDX_W-1:0]         out_idx,
  output logic signed [OFS_W-1:0]  out_ofs,
  output logic signed [DIST_W-1:0] out_dist
);
  logic rst_n_int;

  sao_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  logic                    b_vld, b_ovr, b_neg;
  logic [IDX_W-1:0]        b_idx;
  logic [CNT_W-1:0]        b_cnt;
  logic signed [SUM_W-1:0] b_sum;
  logic signed [OFS_W-1:0] b_ovr_ofs;
  logic [OFS_MAX-1:0]      b_hits;

  sao_thresh_stage #(
    .CNT_W(CNT_W), .SUM_W(SUM_W), .IDX_W(IDX_W),
    .OFS_MAX(OFS_MAX), .OFS_W(OFS_W)
  ) u_thr (
    .clk(clk), .rst_n(rst_n_int),
    .a_vld(in_vld), .a_idx(in_idx), .a_cnt(in_cnt), .a_sum(in_sum),
    .a_ovr(in_ovr), .a_ovr_ofs(in_ovr_ofs),
    .b_vld(b_vld), .b_idx(b_idx), .b_cnt(b_cnt), .b_sum(b_sum),
    .b_ovr(b_ovr), .b_ovr_ofs(b_ovr_ofs), .b_neg(b_neg), .b_hits(b_hits)
  );

  logic                    c_vld;
  logic [IDX_W-1:0]        c_idx;
  logic [CNT_W-1:0]        c_cnt;
  logic signed [SUM_W-1:0] c_sum;
  logic signed [OFS_W-1:0] c_ofs;

  sao_ofs_round #(
    .CNT_W(CNT_W), .SUM_W(SUM_W), .IDX_W(IDX_W),
    .OFS_MAX(OFS_MAX), .OFS_W(OFS_W)
  ) u_rnd (
    .clk(clk), .rst_n(rst_n_int),
    .b_vld(b_vld), .b_idx(b_idx), .b_cnt(b_cnt), .b_sum(b_sum),
    .b_ovr(b_ovr), .b_ovr_ofs(b_ovr_ofs), .b_neg(b_neg), .b_hits(b_hits),
    .c_vld(c_vld), .c_idx(c_idx), .c_cnt(c_cnt), .c_sum(c_sum), .c_ofs(c_ofs)
  );

  sao_dist_calc #(
    .CNT_W(CNT_W), .SUM_W(SUM_W), .IDX_W(IDX_W),
    .OFS_W(OFS_W), .DIST_W(DIST_W)
  ) u_dst (
    .clk(clk), .rst_n(rst_n_int),
    .c_vld(c_vld), .c_idx(c_idx), .c_cnt(c_cnt), .c_sum(c_sum), .c_ofs(c_ofs),
    .d_vld(out_vld), .d_idx(out_idx), .d_ofs(out_ofs), .d_dist(out_dist)
  );
endmodule

// File: rtl/sao_ofs_dist_chk.sv
module sao_ofs_dist_chk #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned SUM_W   = 21,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned OFS_MAX = 7,
  parameter int unsigned OFS_W   = 4,
  parameter int unsigned DIST_W  = 27
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_vld,
  input logic [IDX_W-1:0]         in_idx,
  input logic [CNT_W-1:0]         in_cnt,
  input logic signed [SUM_W-1:0]  in_sum,
  input logic                     in_ovr,
  input logic signed [OFS_W-1:0]  in_ovr_ofs,
  input logic                     out_vld,
  input logic [IDX_W-1:0]         out_idx,
  input logic signed [OFS_W-1:0]  out_ofs,
  input logic signed [DIST_W-1:0] out_dist
);
  localparam int unsigned DEPTH = 3;
  localparam int unsigned WARM  = 6;

  logic [3:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
  end

  logic live;
  assign live = (since_rst >= 4'(WARM));

  logic                    h_vld  [DEPTH];
  logic [IDX_W-1:0]        h_idx  [DEPTH];
  logic [CNT_W-1:0]        h_cnt  [DEPTH];
  logic signed [SUM_W-1:0] h_sum  [DEPTH];
  logic                    h_ovr  [DEPTH];
  logic signed [OFS_W-1:0] h_oofs [DEPTH];

  always_ff @(posedge clk) begin
    h_vld[0] <= in_vld;  h_idx[0] <= in_idx;  h_cnt[0] <= in_cnt;
    h_sum[0] <= in_sum;  h_ovr[0] <= in_ovr;  h_oofs[0] <= in_ovr_ofs;
    for (int k = 1; k < DEPTH; k++) begin
      h_vld[k] <= h_vld[k-1];  h_idx[k] <= h_idx[k-1];  h_cnt[k] <= h_cnt[k-1];
      h_sum[k] <= h_sum[k-1];  h_ovr[k] <= h_ovr[k-1];  h_oofs[k] <= h_oofs[k-1];
    end
  end

  logic signed [DIST_W-1:0] want_dist;
  always_comb begin
    want_dist = DIST_W'(out_ofs) * DIST_W'(out_ofs) * DIST_W'({1'b0, h_cnt[DEPTH-1]})
              - ((DIST_W'(out_ofs) * DIST_W'(h_sum[DEPTH-1])) <<< 1);
  end

  // R7
  vld_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (out_vld == h_vld[DEPTH-1]));

  // R8
  idx_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && out_vld) |-> (out_idx == h_idx[DEPTH-1]));

  // R10
  ofs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($signed(out_ofs) <= $signed(OFS_W'(OFS_MAX)) &&
                 $signed(out_ofs) >= -$signed(OFS_W'(OFS_MAX))));

  // R4
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && out_vld && !h_ovr[DEPTH-1] && h_cnt[DEPTH-1] == '0)
      |-> (out_ofs == '0 && out_dist == '0));

  // R6
  ovr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && out_vld && h_ovr[DEPTH-1]) |-> (out_ofs == h_oofs[DEPTH-1]));

  // R2
  ofs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && out_vld && !h_ovr[DEPTH-1] && out_ofs != '0)
      |-> (out_ofs[OFS_W-1] == h_sum[DEPTH-1][SUM_W-1]));

  // R5
  dist_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && out_vld) |-> (out_dist == want_dist));
endmodule

bind sao_ofs_dist_gen sao_ofs_dist_chk #(
  .CNT_W(CNT_W), .SUM_W(SUM_W), .IDX_W(IDX_W),
  .OFS_MAX(OFS_MAX), .OFS_W(OFS_W), .DIST_W(DIST_W)
) u_chk (.*);

// File: tb/sao_ofs_dist_gen_tb.sv
module sao_ofs_dist_gen_tb;
  localparam int CNT_W = 13, SUM_W = 21, IDX_W = 6, OFS_W = 4, DIST_W = 27;
  localparam int N = 18;

  // sum, count, override flag, override value, expected offset, requirement
  localparam int T_S  [N] = '{-11, 11, 3, 9, -9, 100, -100, 0, 5, 40, 39, 20,
                              7, 6, -4095, -5, -1048576, 1048575};
  localparam int T_C  [N] = '{6, 6, 6, 6, 6, 3, 3, 5, 0, 6, 6, 4,
                              1, 1, 4095, 0, 1, 8191};
  localparam int T_OV [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1,
                              0, 0, 0, 1, 0, 0};
  localparam int T_OO [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, -3,
                              0, 0, 0, 2, 0, 0};
  localparam int T_E  [N] = '{-2, 2, 0, 1, -1, 7, -7, 0, 0, 7, 6, -3,
                              7, 6, -1, 2, -7, 7};
  localparam int T_R  [N] = '{1, 2, 3, 3, 3, 10, 10, 1, 4, 10, 3, 6,
                              10, 1, 2, 6, 10, 10};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [IDX_W-1:0] in_idx = '0;
  logic [CNT_W-1:0] in_cnt = '0;
  logic signed [SUM_W-1:0] in_sum = '0;
  logic in_ovr = 1'b0;
  logic signed [OFS_W-1:0] in_ovr_ofs = '0;
  logic out_vld;
  logic [IDX_W-1:0] out_idx;
  logic signed [OFS_W-1:0] out_ofs;
  logic signed [DIST_W-1:0] out_dist;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sao_ofs_dist_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_idx(in_idx),
    .in_cnt(in_cnt), .in_sum(in_sum), .in_ovr(in_ovr), .in_ovr_ofs(in_ovr_ofs),
    .out_vld(out_vld), .out_idx(out_idx), .out_ofs(out_ofs), .out_dist(out_dist)
  );

  function automatic longint want_dist(input longint o, input longint c, input longint s);
    return o * o * c - 2 * o * s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int i);
    in_vld     = 1'b1;
    in_idx     = IDX_W'(i);
    in_cnt     = CNT_W'(T_C[i]);
    in_sum     = SUM_W'(T_S[i]);
    in_ovr     = (T_OV[i] != 0);
    in_ovr_ofs = OFS_W'(T_OO[i]);
  endtask

  task automatic idle();
    in_vld = 1'b0;
  endtask

  task automatic check_result(input int i);
    string rq;
    rq = $sformatf("R%0d", T_R[i]);
    check(out_vld == 1'b1, "R7 valid", longint'(out_vld), 1);
    check(out_idx == IDX_W'(i), "R8 index", longint'(out_idx), i);
    check(int'(out_ofs) == T_E[i], rq, longint'(out_ofs), T_E[i]);
    check(longint'(out_dist) == want_dist(T_E[i], T_C[i], T_S[i]), "R5 distortion",
          longint'(out_dist), want_dist(T_E[i], T_C[i], T_S[i]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs idle while reset is held
    check(out_vld == 1'b0, "R9 in reset", longint'(out_vld), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check(out_vld == 1'b0, "R9 after release", longint'(out_vld), 0);

    // Table walk, back to back (R1 R2 R3 R4 R5 R6 R8 R10)
    for (int j = 0; j < N + 3; j++) begin
      if (j >= 3) check_result(j - 3);
      if (j < N) drive(j); else idle();
      @(negedge clk);
    end
    check(out_vld == 1'b0, "R7 drain", longint'(out_vld), 0);

    // R7: isolated input appears exactly three edges later, for one cycle
    drive(0);
    @(negedge clk); idle();
    check(out_vld == 1'b0, "R7 lat1", longint'(out_vld), 0);
    @(negedge clk);
    check(out_vld == 1'b0, "R7 lat2", longint'(out_vld), 0);
    @(negedge clk);
    check_result(0);
    @(negedge clk);
    check(out_vld == 1'b0, "R7 single", longint'(out_vld), 0);

    // R9: reset in mid-stream empties the pipeline
    for (int j = 0; j < 2; j++) begin
      drive(j + 5);
      @(negedge clk);
    end
    idle();
    rst_n = 1'b0;
    #1;
    check(out_vld == 1'b0, "R9 mid reset", longint'(out_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      check(out_vld == 1'b0, "R9 flushed", longint'(out_vld), 0);
    end

    // R4 again with a large sum, then an override with a zero count (R6)
    drive(8); in_sum = SUM_W'(-1048576);
    @(negedge clk); idle();
    repeat (2) @(negedge clk);
    check(out_ofs == '0, "R4 ofs", longint'(out_ofs), 0);
    check(out_dist == '0, "R4 dist", longint'(out_dist), 0);
    drive(15);
    @(negedge clk); idle();
    repeat (2) @(negedge clk);
    check_result(15);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end
endmodule